// File: doc/BRIEF.md
# Branch Resolution and Next Program Counter Unit

This block sits in the execute stage of a RISC core whose instructions are all 32 bits wide. Each cycle the core may present a decoded instruction class together with the current program counter, the two source register values, the 16-bit immediate field and the 26-bit jump index field. One clock later the block returns the address of the next instruction to fetch. It also returns a flag that says the flow of control was redirected, a request to write a return address into the fixed link register, and the one-bit result of the signed set-on-less-than comparison.

Conditional branches compare the two register values for equality. Their offsets count words and are measured from the address of the following instruction. Direct jumps keep the top bits of that following address and replace the rest with the word-scaled index. A register jump goes wherever the first source register points. Instruction fetch, the register file and the rest of the ALU live elsewhere.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is cleared to zero at that edge, except `link_addr`, which always carries the link register number (31 by default).
- R2: Results appear exactly one clock after the edge that samples `in_valid` high, and `out_valid` is high for exactly those cycles.
- R3: For classes 0 (sequential), 3 (signed compare), 4 (signed compare with immediate) and 8 to 15 (unassigned), `next_pc` is `pc + 4` and `taken` is 0.
- R4: Class 1 (branch if equal) gives `next_pc = pc + 4 + offset*4` and `taken = 1` when `rs_val == rt_val`. Otherwise it gives `pc + 4` with `taken = 0`.
- R5: Class 2 (branch if not equal) redirects when `rs_val != rt_val`, to the same target as R4. Otherwise it gives `pc + 4` with `taken = 0`.
- R6: The 16-bit offset is taken as signed two's complement before it is scaled. An offset field of 25 moves 100 bytes forward, and 0xFFFD moves 12 bytes back, both from `pc + 4`.
- R7: Class 5 (jump) gives `next_pc = {upper 4 bits of pc+4, jump_idx, 2'b00}` with `taken = 1`. A field of 2500 reaches byte 10000 within the current 256 MB region.
- R8: Class 6 (jump and link) jumps as in R7. It also raises `link_we` with `link_val = pc + 4`. No other class raises `link_we`.
- R9: Class 7 (register jump) gives `next_pc = rs_val` unchanged, with `taken = 1`.
- R10: `slt_out` is 1 for class 3 when `rs_val < rt_val` as signed values. For class 4 it is 1 when `rs_val` is less than the sign-extended immediate. It is 0 in every other case.
- R11: In a cycle where `out_valid` is low, `taken`, `link_we` and `slt_out` are 0, and `next_pc` and `link_val` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction presented this cycle |
| op_class | input | 4 | Decoded control class (see requirements) |
| pc | input | 32 | Address of the current instruction |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| imm16 | input | 16 | Branch offset or compare constant |
| jump_idx | input | 26 | Direct jump index field |
| out_valid | output | 1 | Result registers hold a new result |
| next_pc | output | 32 | Address of the next instruction to fetch |
| taken | output | 1 | Control flow was redirected |
| link_we | output | 1 | Request to write the return address |
| link_addr | output | 5 | Destination register of the return address |
| link_val | output | 32 | Return address, the current pc + 4 |
| slt_out | output | 1 | Signed less-than result |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, a 16-bit offset, a 26-bit jump index and link register 31. These defaults leave 4 region bits above the jump field. That lets the bench place the program counter in a high region, such as 0xA..., where a jump that dropped or corrupted the upper bits gives a visibly wrong target. With 32-bit signed operands the bench can cross the sign boundary in both compares. It can also wrap a backward branch offset, so the sign-extension paths are exercised.

// File: rtl/npc_pkg.sv
// Package npc_pkg
// Shared encoding of the decoded control class that drives the
// next-PC unit. Values 8 to 15 are unassigned and are handled as
// sequential flow by every consumer.
package npc_pkg;

    typedef enum logic [3:0] {
        NPC_SEQ  = 4'd0,  // plain fall-through
        NPC_BEQ  = 4'd1,  // branch when operands are equal
        NPC_BNE  = 4'd2,  // branch when operands differ
        NPC_SLT  = 4'd3,  // signed less-than, register operand
        NPC_SLTI = 4'd4,  // signed less-than, immediate operand
        NPC_JMP  = 4'd5,  // direct jump
        NPC_JAL  = 4'd6,  // direct jump with return-address write
        NPC_JR   = 4'd7   // jump to register value
    } npc_op_e;

    localparam int NPC_OP_W = 4;

endpackage

// File: rtl/npc_target.sv
// Module npc_target
// Computes the three candidate addresses: the fall-through address,
// the PC-relative branch target and the region-relative jump target.
// Assumes XLEN > JIDX_W + 2, so that some region bits remain above
// the jump field, and that every instruction is INSTR_BYTES long.
module npc_target #(
    parameter int XLEN        = 32,
    parameter int IMM_W       = 16,
    parameter int JIDX_W      = 26,
    parameter int INSTR_BYTES = 4
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [IMM_W-1:0]  imm,
    input  logic [JIDX_W-1:0] jidx,
    output logic [XLEN-1:0]   seq_pc,
    output logic [XLEN-1:0]   br_pc,
    output logic [XLEN-1:0]   jmp_pc
);

    localparam int SHIFT    = $clog2(INSTR_BYTES);
    localparam int REGION_W = XLEN - JIDX_W - SHIFT;
    localparam int EXT_W    = XLEN - IMM_W;

    logic [XLEN-1:0] offset_ext;

    // Fall-through address of the following instruction.
    always_comb begin
        seq_pc = pc + XLEN'(INSTR_BYTES);
    end

    // Sign-extend the offset field, then scale it to bytes.
    always_comb begin
        offset_ext = {{EXT_W{imm[IMM_W-1]}}, imm} << SHIFT;
    end

    // The branch target is measured from the following instruction.
    always_comb begin
        br_pc = seq_pc + offset_ext;
    end

    // The jump target keeps the region bits of the following address.
    always_comb begin
        jmp_pc = {seq_pc[XLEN-1 -: REGION_W], jidx, {SHIFT{1'b0}}};
    end

endmodule

// File: rtl/npc_compare.sv
// Module npc_compare
// Operand comparator. Reports register equality for branches, and
// a signed less-than of the first operand against either the second
// register or the sign-extended immediate.
// Assumes two's-complement operands and XLEN >= IMM_W.
module npc_compare #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  a_val,
    input  logic [XLEN-1:0]  b_val,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    output logic             eq,
    output logic             lt
);

    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] rhs;

    // Equality of the two register operands.
    always_comb begin
        eq = (a_val == b_val);
    end

    // Choose the right-hand operand of the less-than compare.
    always_comb begin
        rhs = use_imm ? {{EXT_W{imm[IMM_W-1]}}, imm} : b_val;
    end

    // Signed magnitude compare.
    always_comb begin
        lt = $signed(a_val) < $signed(rhs);
    end

endmodule

// File: rtl/npc_select.sv
// Module npc_select
// Decides, from the control class and the compare flags, which
// candidate address becomes the next PC. Also decides whether the
// flow is redirected, whether a return address is written, and what
// the set-on-less-than bit is. Unassigned classes fall through.
module npc_select
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [NPC_OP_W-1:0] op,
    input  logic                eq,
    input  logic                lt,
    input  logic [XLEN-1:0]     seq_pc,
    input  logic [XLEN-1:0]     br_pc,
    input  logic [XLEN-1:0]     jmp_pc,
    input  logic [XLEN-1:0]     reg_pc,
    output logic [XLEN-1:0]     npc,
    output logic                redirect,
    output logic                link,
    output logic                slt_bit
);

    // Per-class decision on redirect, link and compare result.
    always_comb begin
        redirect = 1'b0;
        link     = 1'b0;
        slt_bit  = 1'b0;
        case (op)
            NPC_BEQ:  redirect = eq;
            NPC_BNE:  redirect = !eq;
            NPC_SLT:  slt_bit  = lt;
            NPC_SLTI: slt_bit  = lt;
            NPC_JMP:  redirect = 1'b1;
            NPC_JAL: begin
                redirect = 1'b1;
                link     = 1'b1;
            end
            NPC_JR:   redirect = 1'b1;
            default:  redirect = 1'b0;
        endcase
    end

    // Address mux driven by the class and the redirect decision.
    always_comb begin
        npc = seq_pc;
        if (redirect) begin
            case (op)
                NPC_BEQ, NPC_BNE: npc = br_pc;
                NPC_JMP, NPC_JAL: npc = jmp_pc;
                NPC_JR:           npc = reg_pc;
                default:          npc = seq_pc;
            endcase
        end
    end

endmodule

// File: rtl/npc_unit.sv
// Module npc_unit (top)
// Registered branch and next-PC stage. Accepts one decoded control
// instruction per cycle and presents its next PC, redirect flag,
// link request and set-on-less-than bit one clock later. The
// datapath is combinational up to a single output register stage.
// The reset is synchronous and active low.
module npc_unit
    import npc_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int IMM_W       = 16,
    parameter int JIDX_W      = 26,
    parameter int REG_ADDR_W  = 5,
    parameter int LINK_REG    = 31,
    parameter int INSTR_BYTES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [NPC_OP_W-1:0]   op_class,
    input  logic [XLEN-1:0]       pc,
    input  logic [XLEN-1:0]       rs_val,
    input  logic [XLEN-1:0]       rt_val,
    input  logic [IMM_W-1:0]      imm16,
    input  logic [JIDX_W-1:0]     jump_idx,
    output logic                  out_valid,
    output logic [XLEN-1:0]       next_pc,
    output logic                  taken,
    output logic                  link_we,
    output logic [REG_ADDR_W-1:0] link_addr,
    output logic [XLEN-1:0]       link_val,
    output logic                  slt_out
);

    logic [XLEN-1:0] seq_pc_c;
    logic [XLEN-1:0] br_pc_c;
    logic [XLEN-1:0] jmp_pc_c;
    logic            eq_c;
    logic            lt_c;
    logic            use_imm_c;
    logic [XLEN-1:0] npc_c;
    logic            redirect_c;
    logic            link_c;
    logic            slt_c;

    // The immediate operand is used only by the immediate compare.
    always_comb begin
        use_imm_c = (op_class == NPC_SLTI);
    end

    npc_target #(
        .XLEN        (XLEN),
        .IMM_W       (IMM_W),
        .JIDX_W      (JIDX_W),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_target (
        .pc     (pc),
        .imm    (imm16),
        .jidx   (jump_idx),
        .seq_pc (seq_pc_c),
        .br_pc  (br_pc_c),
        .jmp_pc (jmp_pc_c)
    );

    npc_compare #(
        .XLEN  (XLEN),
        .IMM_W (IMM_W)
    ) u_compare (
        .a_val   (rs_val),
        .b_val   (rt_val),
        .imm     (imm16),
        .use_imm (use_imm_c),
        .eq      (eq_c),
        .lt      (lt_c)
    );

    npc_select #(
        .XLEN (XLEN)
    ) u_select (
        .op       (op_class),
        .eq       (eq_c),
        .lt       (lt_c),
        .seq_pc   (seq_pc_c),
        .br_pc    (br_pc_c),
        .jmp_pc   (jmp_pc_c),
        .reg_pc   (rs_val),
        .npc      (npc_c),
        .redirect (redirect_c),
        .link     (link_c),
        .slt_bit  (slt_c)
    );

    // The link destination is a fixed register number.
    assign link_addr = REG_ADDR_W'(LINK_REG);

    // Output stage: capture the result, or clear the strobes when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            next_pc   <= '0;
            taken     <= 1'b0;
            link_we   <= 1'b0;
            link_val  <= '0;
            slt_out   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                next_pc  <= npc_c;
                taken    <= redirect_c;
                link_we  <= link_c;
                link_val <= seq_pc_c;
                slt_out  <= slt_c;
            end else begin
                taken    <= 1'b0;
                link_we  <= 1'b0;
                slt_out  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/npc_unit_chk.sv
// Module npc_unit_chk
// Protocol and relation checks for npc_unit, attached by bind.
module npc_unit_chk #(
    parameter int XLEN       = 32,
    parameter int IMM_W      = 16,
    parameter int JIDX_W     = 26,
    parameter int REG_ADDR_W = 5,
    parameter int LINK_REG   = 31
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [3:0]            op_class,
    input logic [XLEN-1:0]       pc,
    input logic [XLEN-1:0]       rs_val,
    input logic [XLEN-1:0]       rt_val,
    input logic [IMM_W-1:0]      imm16,
    input logic [JIDX_W-1:0]     jump_idx,
    input logic                  out_valid,
    input logic [XLEN-1:0]       next_pc,
    input logic                  taken,
    input logic                  link_we,
    input logic [REG_ADDR_W-1:0] link_addr,
    input logic [XLEN-1:0]       link_val,
    input logic                  slt_out
);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    seq_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 4'd0)
        |=> (!taken && next_pc == $past(pc) + XLEN'(4)));

    // R8
    jal_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 4'd6)
        |=> (link_we && link_val == $past(pc) + XLEN'(4)
             && link_addr == REG_ADDR_W'(LINK_REG)));

    // R9
    jr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 4'd7)
        |=> (taken && next_pc == $past(rs_val)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!taken && !link_we && !slt_out));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && out_valid) |=> $stable(next_pc));

    // R4
    beq_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_class == 4'd1 && rs_val != rt_val) |=> !taken);

endmodule

bind npc_unit npc_unit_chk #(
    .XLEN       (XLEN),
    .IMM_W      (IMM_W),
    .JIDX_W     (JIDX_W),
    .REG_ADDR_W (REG_ADDR_W),
    .LINK_REG   (LINK_REG)
) u_chk (.*);

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;

    typedef struct {
        logic [31:0] npc;
        logic        tk;
        logic        lw;
        logic [31:0] lv;
        logic        slt;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_class = '0;
    logic [31:0] pc = '0, rs_val = '0, rt_val = '0;
    logic [15:0] imm16 = '0;
    logic [25:0] jump_idx = '0;
    logic        out_valid, taken, link_we, slt_out;
    logic [31:0] next_pc, link_val;
    logic [4:0]  link_addr;

    int checks = 0;
    int errors = 0;
    exp_t sb[$];
    logic [31:0] last_npc = '0;
    bit done = 0;

    always #2 clk = ~clk;

    npc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_class(op_class),
        .pc(pc), .rs_val(rs_val), .rt_val(rt_val), .imm16(imm16),
        .jump_idx(jump_idx), .out_valid(out_valid), .next_pc(next_pc),
        .taken(taken), .link_we(link_we), .link_addr(link_addr),
        .link_val(link_val), .slt_out(slt_out)
    );

    // Reference built from the requirements text.
    function automatic exp_t model(input logic [3:0] op, input logic [31:0] p,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [15:0] im, input logic [25:0] ji,
                                   input string rq);
        exp_t e;
        logic [31:0] p4 = p + 32'd4;
        logic [31:0] br = p4 + {{14{im[15]}}, im, 2'b00};
        logic [31:0] jt = {p4[31:28], ji, 2'b00};
        e.npc = p4; e.tk = 0; e.lw = 0; e.lv = p4; e.slt = 0; e.req = rq;
        case (op)
            4'd1: if (a == b) begin e.npc = br; e.tk = 1; end
            4'd2: if (a != b) begin e.npc = br; e.tk = 1; end
            4'd3: e.slt = $signed(a) < $signed(b);
            4'd4: e.slt = $signed(a) < $signed({{16{im[15]}}, im});
            4'd5: begin e.npc = jt; e.tk = 1; end
            4'd6: begin e.npc = jt; e.tk = 1; e.lw = 1; end
            4'd7: begin e.npc = a; e.tk = 1; end
            default: ;
        endcase
        return e;
    endfunction

    task automatic send(input logic [3:0] op, input logic [31:0] p,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] im, input logic [25:0] ji,
                        input string rq);
        @(negedge clk);
        in_valid = 1; op_class = op; pc = p; rs_val = a; rt_val = b;
        imm16 = im; jump_idx = ji;
        sb.push_back(model(op, p, a, b, im, ji, rq));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0; op_class = 4'd5; pc = 32'hFFFF_0000;
            rs_val = 32'h1234_5678;
        end
    endtask

    task automatic fail1(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        errors++;
        $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    endtask

    // Monitor: compare each result against the scoreboard front.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                exp_t e;
                bit bad = 0;
                checks++;
                if (sb.size() == 0) begin
                    fail1("R2", "unexpected out_valid", 1, 0);
                end else begin
                    e = sb.pop_front();
                    if (next_pc !== e.npc) begin bad = 1; fail1(e.req, "next_pc", next_pc, e.npc); end
                    if (taken !== e.tk) begin bad = 1; fail1(e.req, "taken", {31'd0, taken}, {31'd0, e.tk}); end
                    if (link_we !== e.lw) begin bad = 1; fail1("R8", "link_we", {31'd0, link_we}, {31'd0, e.lw}); end
                    if (e.lw && link_val !== e.lv) begin bad = 1; fail1("R8", "link_val", link_val, e.lv); end
                    if (link_addr !== 5'd31) begin bad = 1; fail1("R8", "link_addr", {27'd0, link_addr}, 31); end
                    if (slt_out !== e.slt) begin bad = 1; fail1("R10", "slt_out", {31'd0, slt_out}, {31'd0, e.slt}); end
                    if (bad) errors += 0;
                    last_npc = e.npc;
                end
            end else begin
                // R11: idle cycles keep strobes low and next_pc held
                checks++;
                if (taken || link_we || slt_out)
                    fail1("R11", "idle strobes", {29'd0, taken, link_we, slt_out}, 0);
                else if (next_pc !== last_npc)
                    fail1("R11", "idle next_pc", next_pc, last_npc);
            end
        end
    end

    initial begin
        #40000;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs cleared under reset
        checks++;
        if (out_valid || taken || link_we || slt_out || next_pc != 0 || link_val != 0)
            fail1("R1", "reset outputs", next_pc, 0);
        checks++;
        if (link_addr !== 5'd31) fail1("R1", "link_addr", {27'd0, link_addr}, 31);
        rst_n = 1;
        idle(2);
        send(4'd0, 32'h0000_1000, 1, 2, 16'h0005, 26'h5, "R3");
        send(4'd1, 32'h0000_0024, 7, 7, 16'd25, 0, "R4");
        send(4'd1, 32'h0000_0024, 7, 8, 16'd25, 0, "R4");
        send(4'd2, 32'h0000_0100, 3, 4, 16'd25, 0, "R5");
        send(4'd2, 32'h0000_0100, 9, 9, 16'd25, 0, "R5");
        send(4'd1, 32'h0000_0200, 5, 5, 16'hFFFD, 0, "R6");
        send(4'd2, 32'h0000_0008, 1, 0, 16'hFFFC, 0, "R6");
        idle(3);
        send(4'd5, 32'hA000_0040, 0, 0, 0, 26'd2500, "R7");
        send(4'd5, 32'hAFFF_FFFC, 0, 0, 0, 26'h3FF_FFFF, "R7");
        send(4'd6, 32'h5000_0030, 0, 0, 0, 26'd2500, "R8");
        send(4'd7, 32'h0000_0400, 32'h1234_5679, 0, 0, 0, "R9");
        send(4'd3, 32'h0000_0500, 32'hFFFF_FFFF, 1, 0, 0, "R10");
        send(4'd3, 32'h0000_0504, 5, 3, 0, 0, "R10");
        send(4'd3, 32'h0000_0508, 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, "R10");
        send(4'd4, 32'h0000_050C, 32'hFFFF_FFF6, 0, 16'hFFFB, 0, "R10");
        send(4'd4, 32'h0000_0510, 32'd10, 0, 16'hFFFB, 0, "R10");
        send(4'd9, 32'h0000_0600, 4, 4, 16'd25, 26'd99, "R3");
        send(4'd15, 32'h0000_0604, 4, 4, 16'd25, 26'd99, "R3");
        idle(4);
        send(4'd6, 32'h0000_0700, 0, 0, 0, 26'd1, "R8");
        idle(3);
        @(negedge clk);
        done = 1;
        checks++;
        if (sb.size() != 0) fail1("R2", "results missing", sb.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule